// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits beside a memory shared by two processor ports (left and right) and gives them a way to signal each other. Each port drives an active-low chip select, a read/write strobe (high = read, low = write), an address and write data. Two addresses at the very top of the address space are set aside as mailboxes. The highest address minus one belongs to the left port, and the highest address belongs to the right port. Each mailbox holds one data word whose meaning is left to software.

When one port writes the other port's mailbox, the receiving port's active-low interrupt output goes low. The receiving port reads its own mailbox to get the message, and that read drops the interrupt. A mailbox enable input turns the signalling on. With the enable low, the two words are still plain storage but neither interrupt flag moves. Both ports run on one clock. Every flag and read-data update is registered, so it shows after the clock edge that samples the access.

Top module: `mbox_irq_pair`

## Requirements
- R1: After reset both interrupt outputs are high, both stored words are zero and both read-data outputs are zero.
- R2: With the enable high, a right-port write (cs_n=0, we_n=0) to address 0x3FFE drives l_irq_n low after that clock edge. It stays low until it is cleared.
- R3: With the enable high, a left-port read (cs_n=0, we_n=1) of 0x3FFE drives l_irq_n high after that edge.
- R4: In the same way, a left-port write to 0x3FFF drives r_irq_n low, and a right-port read of 0x3FFF drives it high again.
- R5: A read of either mailbox address by a port puts that mailbox's stored word on the port's read data after the edge. If the same word is written in the same cycle, the read returns the contents from before that write. A read of any other address leaves the read data unchanged.
- R6: With mbox_en low, no access changes either interrupt output. Writes to and reads of the two mailbox words still work as storage.
- R7: If a flag is set and cleared in the same cycle, the set wins and the interrupt output is low after the edge.
- R8: If both ports write the same mailbox word in one cycle, the left port's data is stored.
- R9: None of the following changes a flag or a stored word where it would not apply: an access with cs_n high, a port writing its own mailbox (this stores the word but raises nothing), or a read of a non-mailbox address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Active-low asynchronous reset |
| mbox_en | input | 1 | Turns on mailbox interrupt signalling |
| l_cs_n | input | 1 | Left port chip select, active low |
| l_we_n | input | 1 | Left port strobe, 1 = read, 0 = write |
| l_addr | input | 14 | Left port address |
| l_wdata | input | 16 | Left port write data |
| l_rdata | output | 16 | Left port mailbox read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs_n | input | 1 | Right port chip select, active low |
| r_we_n | input | 1 | Right port strobe, 1 = read, 0 = write |
| r_addr | input | 14 | Right port address |
| r_wdata | input | 16 | Right port write data |
| r_rdata | output | 16 | Right port mailbox read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench targets the cycles where the two ports collide:
- A write into a mailbox that arrives while the owner is reading it must leave the interrupt asserted. A design that let the clear win would lose the notice of the new message. That same read must also return the old word; a design that forwarded the write would return the new one.
- Both ports writing one mailbox at once must store the left word. Swapped priority would show the right word on the read-back.

The bench also checks the cases that must do nothing:
- Own-mailbox writes must not raise a flag.
- Reads of a neighbouring address must not clear one.
- A deselected port must not write.
- With the enable low, a flag must hold in either direction.

Any of these faults shows up at once as a wrong interrupt level or a wrong read-back word.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned N_PORTS = 2;

  typedef enum int unsigned {
    PORT_L = 0,
    PORT_R = 1
  } port_e;

  // the other port of the pair
  function automatic int unsigned peer_of(int unsigned p);
    return (N_PORTS - 1) - p;
  endfunction

  function automatic logic is_write(logic cs_n, logic we_n);
    return !cs_n && !we_n;
  endfunction

  function automatic logic is_read(logic cs_n, logic we_n);
    return !cs_n && we_n;
  endfunction

  // pending-flag update: a set beats a clear
  function automatic logic flag_next(logic raised, logic set, logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return raised;
  endfunction
endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec #(
  parameter int unsigned ADDR_W = 14,
  parameter logic [ADDR_W-1:0] OWN_BOX = '0,
  parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              cs_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_own_o,
  output logic              wr_peer_o,
  output logic              rd_own_o,
  output logic              rd_peer_o,
  output logic              set_peer_o,
  output logic              clr_own_o
);
  import mbox_pkg::*;

  logic hit_own, hit_peer, wr_ev, rd_ev;

  assign hit_own  = (addr_i == OWN_BOX);
  assign hit_peer = (addr_i == PEER_BOX);
  assign wr_ev    = is_write(cs_n_i, we_n_i);
  assign rd_ev    = is_read(cs_n_i, we_n_i);

  assign wr_own_o   = wr_ev && hit_own;
  assign wr_peer_o  = wr_ev && hit_peer;
  assign rd_own_o   = rd_ev && hit_own;
  assign rd_peer_o  = rd_ev && hit_peer;
  assign set_peer_o = en_i && wr_peer_o;
  assign clr_own_o  = en_i && rd_own_o;

  // R9
  dec_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_own_o, wr_peer_o, rd_own_o, rd_peer_o}));

  // R9
  dec_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |-> !(set_peer_o || clr_own_o || wr_own_o || wr_peer_o));
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n_o
);
  import mbox_pkg::*;

  logic raised_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raised_q <= 1'b0;
    else        raised_q <= flag_next(raised_q, set_i, clr_i);
  end

  assign irq_n_o = !raised_q;

  // R7
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> !irq_n_o);

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> irq_n_o);

  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(irq_n_o));
endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    wr_own_i,
  input  logic [1:0]                    wr_peer_i,
  input  logic [1:0]                    rd_own_i,
  input  logic [1:0]                    rd_peer_i,
  input  logic [1:0][DATA_W-1:0]        wdata_i,
  output logic [1:0][DATA_W-1:0]        rdata_o
);
  import mbox_pkg::*;

  logic [1:0][DATA_W-1:0] word_q;
  // wr_hit[w][p]: port p writes word w this cycle
  logic [1:0][1:0]        wr_hit;

  for (genvar w = 0; w < 2; w++) begin : g_word
    for (genvar p = 0; p < 2; p++) begin : g_wr
      if (p == w) begin : g_self
        assign wr_hit[w][p] = wr_own_i[p];
      end else begin : g_other
        assign wr_hit[w][p] = wr_peer_i[p];
      end
    end

    // left port has priority on a double write
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              word_q[w] <= '0;
      else if (wr_hit[w][PORT_L]) word_q[w] <= wdata_i[PORT_L];
      else if (wr_hit[w][PORT_R]) word_q[w] <= wdata_i[PORT_R];
    end

    // R8
    store_left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[w][PORT_L] && wr_hit[w][PORT_R]) |=> (word_q[w] == $past(wdata_i[PORT_L])));
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    localparam int unsigned PEER = peer_of(p);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            rdata_o[p] <= '0;
      else if (rd_own_i[p])  rdata_o[p] <= word_q[p];
      else if (rd_peer_i[p]) rdata_o[p] <= word_q[PEER];
    end

    // R5
    store_read_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_own_i[p] |=> (rdata_o[p] == $past(word_q[p])));

    // R5
    store_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_own_i[p] && !rd_peer_i[p]) |=> $stable(rdata_o[p]));
  end
endmodule

// File: rtl/mbox_irq_pair.sv
module mbox_irq_pair #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mbox_en,
  input  logic              l_cs_n,
  input  logic              l_we_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_cs_n,
  input  logic              r_we_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);
  import mbox_pkg::*;

  localparam logic [ADDR_W-1:0] BOX_R = '1;
  localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;

  logic [1:0]              cs_n_v, we_n_v;
  logic [1:0][ADDR_W-1:0]  addr_v;
  logic [1:0][DATA_W-1:0]  wdata_v, rdata_v;
  logic [1:0]              wr_own, wr_peer, rd_own, rd_peer, set_peer, clr_own;
  logic [1:0]              irq_n_v;

  assign cs_n_v  = {r_cs_n, l_cs_n};
  assign we_n_v  = {r_we_n, l_we_n};
  assign addr_v  = {r_addr, l_addr};
  assign wdata_v = {r_wdata, l_wdata};

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam int unsigned PEER = peer_of(p);
    localparam logic [ADDR_W-1:0] OWN_A  = (p == PORT_L) ? BOX_L : BOX_R;
    localparam logic [ADDR_W-1:0] PEER_A = (p == PORT_L) ? BOX_R : BOX_L;

    mbox_port_dec #(.ADDR_W(ADDR_W), .OWN_BOX(OWN_A), .PEER_BOX(PEER_A)) u_dec (
      .clk(clk), .rst_n(rst_n), .en_i(mbox_en),
      .cs_n_i(cs_n_v[p]), .we_n_i(we_n_v[p]), .addr_i(addr_v[p]),
      .wr_own_o(wr_own[p]), .wr_peer_o(wr_peer[p]),
      .rd_own_o(rd_own[p]), .rd_peer_o(rd_peer[p]),
      .set_peer_o(set_peer[p]), .clr_own_o(clr_own[p])
    );

    // port p's flag is set by the peer and cleared by p itself
    mbox_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_peer[PEER]), .clr_i(clr_own[p]),
      .irq_n_o(irq_n_v[p])
    );

    // R2
    top_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mbox_en && wr_peer[PEER]) |=> !irq_n_v[p]);
  end

  mbox_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_own_i(wr_own), .wr_peer_i(wr_peer),
    .rd_own_i(rd_own), .rd_peer_i(rd_peer),
    .wdata_i(wdata_v), .rdata_o(rdata_v)
  );

  assign l_irq_n = irq_n_v[PORT_L];
  assign r_irq_n = irq_n_v[PORT_R];
  assign l_rdata = rdata_v[PORT_L];
  assign r_rdata = rdata_v[PORT_R];

  // R6
  top_disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mbox_en |=> $stable(irq_n_v));
endmodule

// File: tb/sim_mbox_irq_pair.sv
module sim_mbox_irq_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        lc = 1'b1, lw = 1'b1, rc = 1'b1, rw = 1'b1;
  logic [13:0] la = '0, ra = '0;
  logic [15:0] ld = '0, rd = '0;
  logic [15:0] l_rdata, r_rdata;
  logic        l_irq_n, r_irq_n;
  int          checks = 0, errors = 0;
  bit          done = 0;

  localparam logic [13:0] A_L = 14'h3FFE;
  localparam logic [13:0] A_R = 14'h3FFF;

  always #2.5 clk = ~clk;

  mbox_irq_pair u0 (
    .clk(clk), .rst_n(rst_n), .mbox_en(en),
    .l_cs_n(lc), .l_we_n(lw), .l_addr(la), .l_wdata(ld), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_cs_n(rc), .r_we_n(rw), .r_addr(ra), .r_wdata(rd), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle on both ports, sample after the capturing edge
  task automatic step(input logic lcs, input logic lwe, input logic [13:0] lad, input logic [15:0] lwd,
                      input logic rcs, input logic rwe, input logic [13:0] rad, input logic [15:0] rwd);
    lc = lcs; lw = lwe; la = lad; ld = lwd;
    rc = rcs; rw = rwe; ra = rad; rd = rwd;
    @(posedge clk);
    @(negedge clk);
    lc = 1'b1; rc = 1'b1;
  endtask

  task automatic idle();
    step(1, 1, '0, '0, 1, 1, '0, '0);
  endtask

  task automatic t_reset();
    chk("R1 l_irq_n", l_irq_n, 1);
    chk("R1 r_irq_n", r_irq_n, 1);
    chk("R1 l_rdata", l_rdata, 0);
    chk("R1 r_rdata", r_rdata, 0);
    step(0, 1, A_L, '0, 0, 1, A_R, '0);
    chk("R1 left word zero", l_rdata, 0);
    chk("R1 right word zero", r_rdata, 0);
  endtask

  task automatic t_left_flag();
    step(1, 1, '0, '0, 0, 0, A_L, 16'hA5A5);
    chk("R2 l_irq_n low", l_irq_n, 0);
    chk("R2 r_irq_n untouched", r_irq_n, 1);
    idle();
    chk("R2 l_irq_n held", l_irq_n, 0);
    step(0, 1, A_L, '0, 1, 1, '0, '0);
    chk("R3 l_irq_n cleared", l_irq_n, 1);
    chk("R5 l_rdata message", l_rdata, 16'hA5A5);
  endtask

  task automatic t_right_flag();
    step(0, 0, A_R, 16'h1234, 1, 1, '0, '0);
    chk("R4 r_irq_n low", r_irq_n, 0);
    chk("R4 l_irq_n untouched", l_irq_n, 1);
    step(1, 1, '0, '0, 0, 1, A_R, '0);
    chk("R4 r_irq_n cleared", r_irq_n, 1);
    chk("R5 r_rdata message", r_rdata, 16'h1234);
  endtask

  task automatic t_set_clear_same();
    step(0, 1, A_L, '0, 0, 0, A_L, 16'h0F0F);
    chk("R7 set beats clear", l_irq_n, 0);
    chk("R5 read returns old word", l_rdata, 16'hA5A5);
    step(0, 1, A_L, '0, 1, 1, '0, '0);
    chk("R5 new word visible", l_rdata, 16'h0F0F);
    chk("R3 cleared after", l_irq_n, 1);
  endtask

  task automatic t_disabled();
    step(0, 0, A_R, 16'h2222, 1, 1, '0, '0);
    chk("R4 r_irq_n raised before disable", r_irq_n, 0);
    en = 1'b0;
    step(1, 1, '0, '0, 0, 0, A_L, 16'h7777);
    chk("R6 no raise when disabled", l_irq_n, 1);
    step(1, 1, '0, '0, 0, 1, A_R, '0);
    chk("R6 no clear when disabled", r_irq_n, 0);
    chk("R6 word readable when disabled", r_rdata, 16'h2222);
    step(0, 1, A_L, '0, 1, 1, '0, '0);
    chk("R6 disabled write stored", l_rdata, 16'h7777);
    en = 1'b1;
    step(1, 1, '0, '0, 0, 1, A_R, '0);
    chk("R4 clear after re-enable", r_irq_n, 1);
  endtask

  task automatic t_collide();
    step(0, 0, A_R, 16'hBEEF, 0, 0, A_R, 16'hDEAD);
    chk("R4 raised by left write", r_irq_n, 0);
    step(1, 1, '0, '0, 0, 1, A_R, '0);
    chk("R8 left data stored", r_rdata, 16'hBEEF);
    chk("R4 cleared", r_irq_n, 1);
  endtask

  task automatic t_ignored();
    step(1, 0, A_R, 16'h5555, 1, 1, '0, '0);
    chk("R9 deselected no raise", r_irq_n, 1);
    step(0, 0, A_L, 16'h6666, 1, 1, '0, '0);
    chk("R9 own write no raise", l_irq_n, 1);
    step(1, 1, '0, '0, 0, 1, A_R, '0);
    chk("R9 deselected write not stored", r_rdata, 16'hBEEF);
    step(1, 1, '0, '0, 0, 0, A_L, 16'h1111);
    chk("R2 raised again", l_irq_n, 0);
    step(0, 1, 14'h3FFD, '0, 1, 1, '0, '0);
    chk("R9 other address no clear", l_irq_n, 0);
    chk("R5 other address read holds data", l_rdata, 16'h7777);
    step(0, 1, A_L, '0, 1, 1, '0, '0);
    chk("R3 cleared by own read", l_irq_n, 1);
    chk("R5 latest word", l_rdata, 16'h1111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_left_flag();
    t_right_flag();
    t_set_clear_same();
    t_disabled();
    t_collide();
    t_ignored();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule